// File: doc/BRIEF.md
# Fully Associative Micro Translation Cache with Address-Space Tags

This block is a small translation cache placed in front of a memory port. Each entry maps one virtual page number to a physical frame number. The entry is tagged with an address-space identifier and carries a global flag and three permission bits. A lookup presents a virtual address, the access kind and the privilege level. In the same cycle the block answers with a hit flag, the physical address, and an abort flag when the access breaks the entry's permissions. All entries are compared in parallel, so a hit adds no latency.

After a miss, a separate fill port writes a new entry. A fill goes to the lowest-numbered empty slot. Only when every slot is occupied does the replacement policy pick a victim: a round-robin pointer, or a free-running LFSR when the random-mode input is high. Two invalidation inputs are provided. One flushes every entry. The other removes the non-global entries of one address space, so several processes can share the cache without a full flush on every context switch.

Top module: `utlb_top`

## Requirements
- R1: After reset no entry is valid, so every lookup misses (lkHit=0).
- R2: A valid lookup whose page number matches a valid entry returns lkHit=1 in the same cycle. Unless an abort applies, lkPa holds the entry's frame number above the low OFF_W address bits, which are passed through unchanged. An entry written by a fill can be found from the next cycle on.
- R3: A non-global entry matches only when its stored identifier equals curAsid. Entries that share a page number but belong to different identifiers coexist, and each returns its own frame.
- R4: An entry filled with fillGlobal=1 matches whatever the value of curAsid.
- R5: On a hit, a write access (lkAcc=2) to an entry with fillWritable=0 sets lkAbort=1. A write to a writable entry does not abort.
- R6: On a hit, a fetch access (lkAcc=0) to an entry with fillNoExec=1 sets lkAbort=1. A fetch from an executable entry does not abort.
- R7: On a hit, a user access (lkUser=1) to an entry with fillUserOk=0 sets lkAbort=1, while a privileged read of the same entry is granted. Whenever lkAbort=1, lkHit stays 1 and lkPa is zero.
- R8: A fill never evicts a valid entry while an invalid slot exists. Fills go to the lowest-numbered invalid slot.
- R9: With replRandom=0 and all slots valid, victims are taken in ascending slot order, wrapping after the last slot. The pointer starts at slot 0 after reset and advances only on fills that evict.
- R10: With replRandom=1 and all slots valid, a fill evicts exactly one existing entry, and the new entry hits afterwards.
- R11: A cycle with invAll=1 leaves no valid entry.
- R12: A cycle with invAsidValid=1 removes exactly the non-global entries whose identifier equals invAsid. Global entries and entries of other identifiers remain.
- R13: With lkValid=0, lkHit, lkAbort and lkPa are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkVa | input | VPN_W+OFF_W | Virtual address to translate |
| lkAcc | input | 2 | Access kind: 0 fetch, 1 read, 2 write |
| lkUser | input | 1 | 1 for user-level access, 0 privileged |
| curAsid | input | ASID_W | Identifier of the running address space |
| lkHit | output | 1 | Translation found |
| lkAbort | output | 1 | Hit with a permission violation |
| lkPa | output | PFN_W+OFF_W | Physical address, zero on miss or abort |
| fillValid | input | 1 | Write one entry |
| fillVpn | input | VPN_W | Page number of the new entry |
| fillPfn | input | PFN_W | Frame number of the new entry |
| fillAsid | input | ASID_W | Identifier tag of the new entry |
| fillGlobal | input | 1 | New entry matches any identifier |
| fillWritable | input | 1 | Writes allowed |
| fillUserOk | input | 1 | User-level access allowed |
| fillNoExec | input | 1 | Fetches forbidden |
| invAll | input | 1 | Invalidate every entry |
| invAsidValid | input | 1 | Invalidate entries of one identifier |
| invAsid | input | ASID_W | Identifier to invalidate |
| replRandom | input | 1 | 1 selects LFSR replacement, 0 round-robin |

## Verification
Random replacement is the hardest case to reach and to judge from the ports. It needs every one of the 32 slots valid, and the victim comes from an LFSR whose state the bench does not model. The bench fills the cache to capacity with distinct pages and then issues random-mode fills. After each one it pauses the per-cycle comparison and probes every entry the model holds. Exactly one probe must miss, and that slot is then given to the new entry in the model. The round-robin order after a selective flush is also checked: the refill must land in the holes, and the next eviction must hit the slot that the pointer reached before the flush.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } accKind_e;

  typedef struct packed {
    logic canWrite;
    logic userOk;
    logic noExec;
  } perm_t;

  // strobes from the control side to the entry store
  typedef struct packed {
    logic wr;
    logic clrAll;
    logic clrAsid;
  } ctlStrobe_t;

endpackage

// File: rtl/utlb_ctrl.sv
module utlb_ctrl
  import utlb_pkg::*;
#(
  parameter int N = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fillValid,
  input  logic                 invAll,
  input  logic                 invAsidValid,
  input  logic                 replRandom,
  input  logic [N-1:0]         validVec,
  output ctlStrobe_t           strobe,
  output logic [$clog2(N)-1:0] wrIdx
);
  localparam int IDX_W  = $clog2(N);
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] TAPS = 16'hB400;

  logic [IDX_W-1:0]  rrPtr;
  logic [LFSR_W-1:0] lfsr;
  logic [IDX_W-1:0]  freeIdx;
  logic [IDX_W-1:0]  rndIdx;
  logic              hasFree;
  logic              evict;

  // lowest-numbered empty slot
  always_comb begin
    freeIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!validVec[i]) freeIdx = IDX_W'(i);
    end
  end

  assign hasFree = ~&validVec;
  assign rndIdx  = (int'(lfsr[IDX_W-1:0]) >= N) ? IDX_W'(int'(lfsr[IDX_W-1:0]) - N)
                                                : lfsr[IDX_W-1:0];
  assign evict   = fillValid && !hasFree;
  assign wrIdx   = hasFree ? freeIdx : (replRandom ? rndIdx : rrPtr);

  assign strobe.wr      = fillValid;
  assign strobe.clrAll  = invAll;
  assign strobe.clrAsid = invAsidValid && !invAll;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
      lfsr  <= LFSR_W'(1);
    end else begin
      lfsr <= {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? TAPS : '0);
      if (evict && !replRandom) begin
        rrPtr <= (int'(rrPtr) == N - 1) ? '0 : rrPtr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/utlb_data.sv
module utlb_data
  import utlb_pkg::*;
#(
  parameter int N      = 32,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  parameter int OFF_W  = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobe_t             strobe,
  input  logic [$clog2(N)-1:0]   wrIdx,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [PFN_W-1:0]       fillPfn,
  input  logic [ASID_W-1:0]      fillAsid,
  input  logic                   fillGlobal,
  input  perm_t                  fillPerm,
  input  logic [ASID_W-1:0]      invAsid,
  input  logic                   lkValid,
  input  logic [VPN_W+OFF_W-1:0] lkVa,
  input  logic [1:0]             lkAcc,
  input  logic                   lkUser,
  input  logic [ASID_W-1:0]      curAsid,
  output logic [N-1:0]           validVec,
  output logic                   lkHit,
  output logic                   lkAbort,
  output logic [PFN_W+OFF_W-1:0] lkPa
);
  logic [N-1:0]        vld;
  logic [VPN_W-1:0]    eVpn  [N];
  logic [PFN_W-1:0]    ePfn  [N];
  logic [ASID_W-1:0]   eAsid [N];
  logic [N-1:0]        eGlb;
  perm_t               ePerm [N];

  logic [N-1:0]        hitVec;
  logic [VPN_W-1:0]    lkVpn;
  logic [PFN_W-1:0]    selPfn;
  perm_t               selPerm;
  logic                anyHit;
  logic                deny;

  assign lkVpn    = lkVa[VPN_W+OFF_W-1:OFF_W];
  assign validVec = vld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (strobe.clrAll) vld[i] <= 1'b0;
        else if (strobe.clrAsid && !eGlb[i] && eAsid[i] == invAsid) vld[i] <= 1'b0;
      end
      if (strobe.wr) begin
        vld[wrIdx]   <= 1'b1;
        eVpn[wrIdx]  <= fillVpn;
        ePfn[wrIdx]  <= fillPfn;
        eAsid[wrIdx] <= fillAsid;
        eGlb[wrIdx]  <= fillGlobal;
        ePerm[wrIdx] <= fillPerm;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : gMatch
    assign hitVec[g] = vld[g] && eVpn[g] == lkVpn && (eGlb[g] || eAsid[g] == curAsid);
  end

  always_comb begin
    selPfn  = '0;
    selPerm = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        selPfn  = ePfn[i];
        selPerm = ePerm[i];
      end
    end
  end

  assign anyHit = lkValid && |hitVec;
  assign deny   = (lkAcc == ACC_WRITE && !selPerm.canWrite)
               || (lkAcc == ACC_FETCH && selPerm.noExec)
               || (lkUser && !selPerm.userOk);

  assign lkHit   = anyHit;
  assign lkAbort = anyHit && deny;
  assign lkPa    = (anyHit && !deny) ? {selPfn, lkVa[OFF_W-1:0]} : '0;

endmodule

// File: rtl/utlb_top.sv
module utlb_top
  import utlb_pkg::*;
#(
  parameter int N      = 32,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  parameter int OFF_W  = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lkValid,
  input  logic [VPN_W+OFF_W-1:0] lkVa,
  input  logic [1:0]             lkAcc,
  input  logic                   lkUser,
  input  logic [ASID_W-1:0]      curAsid,
  output logic                   lkHit,
  output logic                   lkAbort,
  output logic [PFN_W+OFF_W-1:0] lkPa,
  input  logic                   fillValid,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [PFN_W-1:0]       fillPfn,
  input  logic [ASID_W-1:0]      fillAsid,
  input  logic                   fillGlobal,
  input  logic                   fillWritable,
  input  logic                   fillUserOk,
  input  logic                   fillNoExec,
  input  logic                   invAll,
  input  logic                   invAsidValid,
  input  logic [ASID_W-1:0]      invAsid,
  input  logic                   replRandom
);
  localparam int IDX_W = $clog2(N);

  ctlStrobe_t       strobe;
  logic [IDX_W-1:0] wrIdx;
  logic [N-1:0]     validVec;
  perm_t            fillPerm;

  assign fillPerm = '{canWrite: fillWritable, userOk: fillUserOk, noExec: fillNoExec};

  utlb_ctrl #(.N(N)) uCtrl (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .invAll(invAll),
    .invAsidValid(invAsidValid), .replRandom(replRandom), .validVec(validVec),
    .strobe(strobe), .wrIdx(wrIdx)
  );

  utlb_data #(.N(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .OFF_W(OFF_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx),
    .fillVpn(fillVpn), .fillPfn(fillPfn), .fillAsid(fillAsid), .fillGlobal(fillGlobal),
    .fillPerm(fillPerm), .invAsid(invAsid), .lkValid(lkValid), .lkVa(lkVa),
    .lkAcc(lkAcc), .lkUser(lkUser), .curAsid(curAsid), .validVec(validVec),
    .lkHit(lkHit), .lkAbort(lkAbort), .lkPa(lkPa)
  );

endmodule

// File: rtl/utlb_chk.sv
module utlb_chk #(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  parameter int OFF_W  = 12
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   lkValid,
  input logic [VPN_W+OFF_W-1:0] lkVa,
  input logic [ASID_W-1:0]      curAsid,
  input logic                   lkHit,
  input logic                   lkAbort,
  input logic [PFN_W+OFF_W-1:0] lkPa,
  input logic                   fillValid,
  input logic [VPN_W-1:0]       fillVpn,
  input logic [ASID_W-1:0]      fillAsid,
  input logic                   fillGlobal,
  input logic                   invAll,
  input logic                   invAsidValid
);
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |-> (!lkHit && !lkAbort && lkPa == '0));

  // R7
  abort_has_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkAbort |-> (lkHit && lkPa == '0));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkHit && !lkAbort) |-> lkPa[OFF_W-1:0] == lkVa[OFF_W-1:0]);

  // R11
  flush_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invAll && !fillValid) |=> !lkHit);

  // R2
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !invAll && !invAsidValid) |=>
      (!(lkValid && lkVa[VPN_W+OFF_W-1:OFF_W] == $past(fillVpn)
         && ($past(fillGlobal) || curAsid == $past(fillAsid))) || lkHit));

endmodule

bind utlb_top utlb_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .OFF_W(OFF_W)) uChk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVa(lkVa), .curAsid(curAsid),
  .lkHit(lkHit), .lkAbort(lkAbort), .lkPa(lkPa), .fillValid(fillValid),
  .fillVpn(fillVpn), .fillAsid(fillAsid), .fillGlobal(fillGlobal),
  .invAll(invAll), .invAsidValid(invAsidValid)
);

// File: tb/tb_utlb_top.sv
module tb_utlb_top;
  localparam int CLK_P = 10;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkValid = 0; logic [31:0] lkVa = 0; logic [1:0] lkAcc = 0; logic lkUser = 0;
  logic [7:0] curAsid = 0;
  logic lkHit, lkAbort; logic [31:0] lkPa;
  logic fillValid = 0; logic [19:0] fillVpn = 0; logic [19:0] fillPfn = 0;
  logic [7:0] fillAsid = 0; logic fillGlobal = 0, fillWritable = 0, fillUserOk = 0, fillNoExec = 0;
  logic invAll = 0, invAsidValid = 0; logic [7:0] invAsid = 0; logic replRandom = 0;

  always #(CLK_P/2) clk = ~clk;

  utlb_top dut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVa(lkVa), .lkAcc(lkAcc), .lkUser(lkUser),
    .curAsid(curAsid), .lkHit(lkHit), .lkAbort(lkAbort), .lkPa(lkPa),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPfn(fillPfn), .fillAsid(fillAsid),
    .fillGlobal(fillGlobal), .fillWritable(fillWritable), .fillUserOk(fillUserOk),
    .fillNoExec(fillNoExec), .invAll(invAll), .invAsidValid(invAsidValid),
    .invAsid(invAsid), .replRandom(replRandom)
  );

  int checks = 0, fails = 0;
  string phaseTag = "R1";
  bit skipCmp = 0;

  // reference model: slot-indexed, round-robin counter, pending random fill
  bit mV[N]; logic [19:0] mVpn[N]; logic [19:0] mPfn[N]; logic [7:0] mAsid[N];
  bit mG[N]; bit mW[N]; bit mU[N]; bit mX[N];
  int rr = 0; int fi;
  bit pend = 0; logic [19:0] pVpn, pPfn; logic [7:0] pAsid; bit pG, pW, pU, pX;

  task automatic putSlot(int s, logic [19:0] v, logic [19:0] p, logic [7:0] a, bit g, bit w, bit u, bit x);
    mV[s] = 1; mVpn[s] = v; mPfn[s] = p; mAsid[s] = a; mG[s] = g; mW[s] = w; mU[s] = u; mX[s] = x;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) mV[i] = 0;
      rr = 0; pend = 0;
    end else begin
      fi = -1;
      for (int i = N - 1; i >= 0; i--) if (!mV[i]) fi = i;
      if (invAll) for (int i = 0; i < N; i++) mV[i] = 0;
      else if (invAsidValid)
        for (int i = 0; i < N; i++) if (!mG[i] && mAsid[i] == invAsid) mV[i] = 0;
      if (fillValid) begin
        if (fi >= 0) putSlot(fi, fillVpn, fillPfn, fillAsid, fillGlobal, fillWritable, fillUserOk, fillNoExec);
        else if (replRandom) begin
          pend = 1; pVpn = fillVpn; pPfn = fillPfn; pAsid = fillAsid;
          pG = fillGlobal; pW = fillWritable; pU = fillUserOk; pX = fillNoExec;
        end else begin
          putSlot(rr, fillVpn, fillPfn, fillAsid, fillGlobal, fillWritable, fillUserOk, fillNoExec);
          rr = (rr + 1) % N;
        end
      end
    end
  end

  task automatic modelLook(output bit h, output bit ab, output logic [31:0] pa);
    bit deny;
    int s = -1;
    h = 0; ab = 0; pa = 0;
    if (!lkValid) return;
    for (int i = N - 1; i >= 0; i--)
      if (mV[i] && mVpn[i] == lkVa[31:12] && (mG[i] || mAsid[i] == curAsid)) s = i;
    if (s < 0) return;
    h = 1;
    deny = (lkAcc == 2 && !mW[s]) || (lkAcc == 0 && mX[s]) || (lkUser && !mU[s]);
    ab = deny;
    pa = deny ? 32'h0 : {mPfn[s], lkVa[11:0]};
  endtask

  task automatic check(bit ok, string tag, bit h, bit ab, logic [31:0] pa,
                       bit eh, bit eab, logic [31:0] epa);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual hit=%0b abort=%0b pa=%h expected hit=%0b abort=%0b pa=%h",
               tag, h, ab, pa, eh, eab, epa);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !skipCmp) begin
      bit eh, eab; logic [31:0] epa;
      modelLook(eh, eab, epa);
      check(lkHit == eh && lkAbort == eab && lkPa == epa, phaseTag, lkHit, lkAbort, lkPa, eh, eab, epa);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic look(logic [19:0] v, logic [11:0] off, logic [1:0] acc, bit usr, logic [7:0] asid,
                      bit eh, bit eab, logic [31:0] epa, string tag);
    lkValid = 1; lkVa = {v, off}; lkAcc = acc; lkUser = usr; curAsid = asid;
    @(negedge clk); #1;
    check(lkHit == eh && lkAbort == eab && lkPa == epa, tag, lkHit, lkAbort, lkPa, eh, eab, epa);
    step();
    lkValid = 0;
  endtask

  task automatic fill(logic [19:0] v, logic [19:0] p, logic [7:0] a, bit g, bit w, bit u, bit x);
    fillValid = 1; fillVpn = v; fillPfn = p; fillAsid = a;
    fillGlobal = g; fillWritable = w; fillUserOk = u; fillNoExec = x;
    step();
    fillValid = 0;
  endtask

  // R10: random-mode fill, then locate the single evicted slot by probing
  task automatic randomFill(logic [19:0] v, logic [19:0] p, logic [7:0] a);
    int misses = 0, victim = -1;
    skipCmp = 1;
    fill(v, p, a, 0, 1, 1, 0);
    for (int i = 0; i < N; i++) begin
      if (mV[i]) begin
        lkValid = 1; lkVa = {mVpn[i], 12'h0}; lkAcc = 1; lkUser = 0; curAsid = mAsid[i];
        @(negedge clk); #1;
        if (!lkHit) begin misses++; victim = i; end
        step();
      end
    end
    lkValid = 0;
    check(misses == 1 && pend, "R10 evicted count", misses == 1, pend, 32'(misses), 1, 1, 32'd1);
    if (victim >= 0) putSlot(victim, pVpn, pPfn, pAsid, pG, pW, pU, pX);
    pend = 0;
    skipCmp = 0;
    look(v, 12'h0, 1, 0, a, 1, 0, {p, 12'h0}, "R10 new entry hits");
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    phaseTag = "R1";
    look(20'h00010, 12'h123, 1, 0, 8'd5, 0, 0, 0, "R1 empty after reset");
    look(20'h00000, 12'h000, 0, 1, 8'd0, 0, 0, 0, "R1 empty after reset vpn0");

    phaseTag = "R2/R3";
    fill(20'h00010, 20'hABCDE, 8'd5, 0, 1, 1, 0);
    look(20'h00010, 12'h123, 1, 1, 8'd5, 1, 0, 32'hABCDE123, "R2 hit pa");
    look(20'h00010, 12'h123, 1, 1, 8'd6, 0, 0, 0, "R3 other asid misses");
    fill(20'h00010, 20'h11111, 8'd6, 0, 1, 1, 0);
    look(20'h00010, 12'hFFF, 1, 1, 8'd6, 1, 0, 32'h11111FFF, "R3 coexist asid6");
    look(20'h00010, 12'h123, 1, 1, 8'd5, 1, 0, 32'hABCDE123, "R3 coexist asid5");

    phaseTag = "R4-R7";
    fill(20'h00020, 20'h22222, 8'd0, 1, 0, 0, 1);
    look(20'h00020, 12'h456, 1, 0, 8'd9, 1, 0, 32'h22222456, "R4 global any asid");
    look(20'h00020, 12'h456, 2, 0, 8'd9, 1, 1, 0, "R5 write read-only aborts");
    look(20'h00020, 12'h456, 0, 0, 8'd9, 1, 1, 0, "R6 fetch no-exec aborts");
    look(20'h00020, 12'h456, 1, 1, 8'd9, 1, 1, 0, "R7 user to kernel-only aborts");
    fill(20'h00030, 20'h33333, 8'd5, 0, 1, 1, 0);
    look(20'h00030, 12'h010, 2, 1, 8'd5, 1, 0, 32'h33333010, "R5 writable ok");
    look(20'h00030, 12'h020, 0, 1, 8'd5, 1, 0, 32'h33333020, "R6 executable ok");

    phaseTag = "R8/R9";
    for (int i = 0; i < 28; i++) fill(20'h00100 + 20'(i), 20'h40000 + 20'(i), 8'd7, 0, 1, 1, 0);
    look(20'h00010, 12'h0, 1, 0, 8'd5, 1, 0, 32'hABCDE000, "R8 full no eviction");
    fill(20'h00200, 20'h50000, 8'd7, 0, 1, 1, 0);
    look(20'h00010, 12'h0, 1, 0, 8'd5, 0, 0, 0, "R9 slot0 evicted first");
    look(20'h00010, 12'h0, 1, 0, 8'd6, 1, 0, 32'h11111000, "R9 slot1 kept");
    fill(20'h00201, 20'h50001, 8'd7, 0, 1, 1, 0);
    look(20'h00010, 12'h0, 1, 0, 8'd6, 0, 0, 0, "R9 slot1 evicted second");

    phaseTag = "R12";
    invAsidValid = 1; invAsid = 8'd7; step(); invAsidValid = 0;
    look(20'h00100, 12'h0, 1, 0, 8'd7, 0, 0, 0, "R12 asid7 removed");
    look(20'h00030, 12'h0, 1, 0, 8'd5, 1, 0, 32'h33333000, "R12 other asid kept");
    look(20'h00020, 12'h0, 1, 0, 8'd7, 1, 0, 32'h22222000, "R12 global kept");
    invAsidValid = 1; invAsid = 8'd0; step(); invAsidValid = 0;
    look(20'h00020, 12'h0, 1, 0, 8'd0, 1, 0, 32'h22222000, "R12 global immune");

    phaseTag = "R8/R9";
    for (int i = 0; i < 30; i++) fill(20'h00300 + 20'(i), 20'h60000 + 20'(i), 8'd8, 0, 1, 1, 0);
    look(20'h00030, 12'h0, 1, 0, 8'd5, 1, 0, 32'h33333000, "R8 holes refilled first");
    look(20'h00020, 12'h0, 1, 0, 8'd8, 1, 0, 32'h22222000, "R8 global not evicted");
    fill(20'h00380, 20'h70000, 8'd8, 0, 1, 1, 0);
    look(20'h00020, 12'h0, 1, 0, 8'd8, 0, 0, 0, "R9 pointer resumes at slot2");

    phaseTag = "R10";
    replRandom = 1;
    for (int k = 0; k < 3; k++) randomFill(20'h00400 + 20'(k), 20'h7A000 + 20'(k), 8'd8);
    replRandom = 0;

    phaseTag = "R11";
    invAll = 1; step(); invAll = 0;
    look(20'h00030, 12'h0, 1, 0, 8'd5, 0, 0, 0, "R11 flushed");
    look(20'h00300, 12'h0, 1, 0, 8'd8, 0, 0, 0, "R11 flushed asid8");

    phaseTag = "R13";
    fill(20'h00010, 20'hABCDE, 8'd5, 0, 1, 1, 0);
    lkValid = 0; lkVa = {20'h00010, 12'h123}; curAsid = 8'd5; lkAcc = 1;
    @(negedge clk); #1;
    check(!lkHit && !lkAbort && lkPa == 0, "R13 idle outputs", lkHit, lkAbort, lkPa, 0, 0, 0);
    step();
    look(20'h00010, 12'h123, 1, 0, 8'd5, 1, 0, 32'hABCDE123, "R13 same va valid hits");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule